// File: doc/BRIEF.md
# Bus Transaction Event Logger

This block sits beside a slave bus and watches it without touching it. For each access it can produce a record of one of three kinds: the arrival of a new request, the final beat of a read response, or the final beat of a write. Each kind has its own enable bit. Each kind also has its own filtering depth. New requests pass through four filters: master, address range, data class and direction. Final read beats pass through a master filter only. Final write beats are never filtered.

A new-request record carries the master ID, the transaction ID, the direction and a 10-bit window of the address. A shift setting selects the window. A final-read record carries the master ID and the transaction ID. A final-write record carries only its kind.

Records go into a small FIFO. A downstream consumer drains the FIFO one record per cycle. When the FIFO has no room, records are dropped and a sticky flag is set. That flag then appears in the next record that the FIFO accepts. A level trigger input can gate all logging. A one-cycle trigger output pulse marks each cycle in which a filtered event took place.

Top module: `bus_event_logger`

## Requirements
- R1: After reset the FIFO is empty (`recValid` low), `trigOut` is low and the overflow flag is clear.
- R2: A new request is logged only when `enNewReq` is high and all four filters pass. The master filter passes when `(reqMaster ^ nrMasterId) & nrMasterMask` is zero. The address filter passes when `addrLo <= reqAddr <= addrHi`. The class filter passes when `classMask[reqClass]` is set, with classes 0 = instruction, 1 = data and 2 = DMA; class 3 never passes. The direction filter passes when `dirMask[0]` is set for a read or `dirMask[1]` is set for a write.
- R3: A final read beat is logged when `enLastRd` is high and `(rdLastMaster ^ lrMasterId) & lrMasterMask` is zero. No other filter applies to it. A final write beat is logged whenever `enLastWr` is high.
- R4: With its enable bit low, an event kind produces no record and no trigger pulse.
- R5: A record is `{kind[1:0], ovf, write, master, xid, slice[9:0]}`, MSB first. The kind codes are 1 = new request, 2 = final read and 3 = final write. Any field that is not part of a kind's payload is zero.
- R6: The address slice is `(reqAddr >> addrShift)[9:0]`. Address bits above the top of `reqAddr` read as zero.
- R7: When several kinds are logged in one cycle, they enter the FIFO in the order new request, final read, final write.
- R8: Records leave in the order they were written. `recData` shows the oldest record while `recValid` is high. `recPop` removes that record. At most DEPTH records are held.
- R9: Room in the FIFO is judged on the count at the start of the cycle; a pop in the same cycle does not make room. A record that finds no room is dropped, and a sticky overflow flag is set. The next accepted record carries `ovf = 1`, and the flag is then cleared.
- R10: When `trigQualEn` is high, nothing is logged while `trigIn` is low.
- R11: `trigOut` is high for one cycle, the cycle after any event passed its filters, when `trigOutEn` is high. This holds even if the event's record was dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| enNewReq | input | 1 | Enable new-request records |
| enLastRd | input | 1 | Enable final-read records |
| enLastWr | input | 1 | Enable final-write records |
| addrShift | input | 5 | Low bit position of the address slice |
| nrMasterId | input | MW | New-request master compare value |
| nrMasterMask | input | MW | New-request master compare mask |
| addrLo | input | AW | Address range lower bound (inclusive) |
| addrHi | input | AW | Address range upper bound (inclusive) |
| classMask | input | 3 | Allowed data classes |
| dirMask | input | 2 | Allowed directions: bit0 read, bit1 write |
| lrMasterId | input | MW | Final-read master compare value |
| lrMasterMask | input | MW | Final-read master compare mask |
| trigQualEn | input | 1 | Gate logging with trigIn |
| trigIn | input | 1 | Level trigger qualifier |
| trigOutEn | input | 1 | Enable trigger output pulse |
| reqValid | input | 1 | New request accepted on the bus |
| reqMaster | input | MW | Request master ID |
| reqXid | input | XW | Request transaction ID |
| reqWrite | input | 1 | Request is a write |
| reqClass | input | 2 | Request data class |
| reqAddr | input | AW | Request address |
| rdLastValid | input | 1 | Final read beat on the bus |
| rdLastMaster | input | MW | Master ID of the final read beat |
| rdLastXid | input | XW | Transaction ID of the final read beat |
| wrLastValid | input | 1 | Final write beat on the bus |
| recPop | input | 1 | Consumer takes the head record |
| recValid | output | 1 | FIFO holds a record |
| recData | output | 2+2+MW+XW+10 | Head record |
| trigOut | output | 1 | Trigger pulse |

## Verification
The hardest case to reach is a cycle in which all three kinds arrive together while the FIFO has only one or two free slots. In that cycle the earlier kinds are accepted, the later ones are dropped, and the overflow flag must land on a later record. The stimulus reaches it in two ways. It fills the FIFO with pops held off and then injects triple events. It also runs long random stretches with dense events and sparse pops, so that the occupancy sits near full. A reference queue in the bench follows the same space rule and predicts every record and every trigger pulse.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  typedef struct packed {
    logic nrPush;
    logic lrPush;
    logic lwPush;
  } evStrobe_t;

  localparam logic [1:0] KIND_NR = 2'd1;
  localparam logic [1:0] KIND_LR = 2'd2;
  localparam logic [1:0] KIND_LW = 2'd3;
endpackage

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
  import evlog_pkg::*;
#(
  parameter int MW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enNewReq,
  input  logic          enLastRd,
  input  logic          enLastWr,
  input  logic [MW-1:0] nrMasterId,
  input  logic [MW-1:0] nrMasterMask,
  input  logic [AW-1:0] addrLo,
  input  logic [AW-1:0] addrHi,
  input  logic [2:0]    classMask,
  input  logic [1:0]    dirMask,
  input  logic [MW-1:0] lrMasterId,
  input  logic [MW-1:0] lrMasterMask,
  input  logic          trigQualEn,
  input  logic          trigIn,
  input  logic          trigOutEn,
  input  logic          reqValid,
  input  logic [MW-1:0] reqMaster,
  input  logic          reqWrite,
  input  logic [1:0]    reqClass,
  input  logic [AW-1:0] reqAddr,
  input  logic          rdLastValid,
  input  logic [MW-1:0] rdLastMaster,
  input  logic          wrLastValid,
  output evStrobe_t     stb,
  output logic          trigOut
);
  logic qual, masterOk, addrOk, classOk, dirOk, lrOk;

  always_comb begin
    qual     = !trigQualEn || trigIn;
    masterOk = ((reqMaster ^ nrMasterId) & nrMasterMask) == '0;
    addrOk   = (reqAddr >= addrLo) && (reqAddr <= addrHi);
    case (reqClass)
      2'd0:    classOk = classMask[0];
      2'd1:    classOk = classMask[1];
      2'd2:    classOk = classMask[2];
      default: classOk = 1'b0;
    endcase
    dirOk = reqWrite ? dirMask[1] : dirMask[0];
    lrOk  = ((rdLastMaster ^ lrMasterId) & lrMasterMask) == '0;

    stb.nrPush = qual && enNewReq && reqValid && masterOk && addrOk && classOk && dirOk;
    stb.lrPush = qual && enLastRd && rdLastValid && lrOk;
    stb.lwPush = qual && enLastWr && wrLastValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigOut <= 1'b0;
    else       trigOut <= trigOutEn && (stb.nrPush || stb.lrPush || stb.lwPush);
  end

  // R10
  qual_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigQualEn && !trigIn) |-> (stb == '0));

  // R11
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(trigOutEn));
endmodule

// File: rtl/evlog_data.sv
module evlog_data
  import evlog_pkg::*;
#(
  parameter int MW    = 4,
  parameter int XW    = 4,
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int RW   = 4 + MW + XW + 10,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  evStrobe_t     stb,
  input  logic [4:0]    addrShift,
  input  logic [MW-1:0] reqMaster,
  input  logic [XW-1:0] reqXid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [MW-1:0] rdLastMaster,
  input  logic [XW-1:0] rdLastXid,
  input  logic          recPop,
  output logic          recValid,
  output logic [RW-1:0] recData
);
  logic [RW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          ovfSticky;

  logic [2:0]          pushArr, acc;
  logic [RW-1:0]       recs [3];
  logic [PW-1:0]       ofs [3];
  logic [CW-1:0]       used;
  logic                anyDrop, firstDone, doPop;
  logic [AW+9:0]       wideAddr;
  logic [9:0]          slice;

  always_comb begin
    wideAddr = {10'b0, reqAddr} >> addrShift;
    slice    = wideAddr[9:0];
    pushArr  = {stb.lwPush, stb.lrPush, stb.nrPush};
    recs[0]  = {KIND_NR, 1'b0, reqWrite, reqMaster, reqXid, slice};
    recs[1]  = {KIND_LR, 1'b0, 1'b0, rdLastMaster, rdLastXid, 10'b0};
    recs[2]  = {KIND_LW, 1'b0, 1'b0, {MW{1'b0}}, {XW{1'b0}}, 10'b0};
    used      = count;
    acc       = '0;
    anyDrop   = 1'b0;
    firstDone = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ofs[i] = '0;
      if (pushArr[i]) begin
        if (used < CW'(DEPTH)) begin
          acc[i] = 1'b1;
          ofs[i] = PW'(used - count);
          recs[i][RW-3] = ovfSticky && !firstDone;
          firstDone = 1'b1;
          used = used + 1'b1;
        end else begin
          anyDrop = 1'b1;
        end
      end
    end
    doPop = recPop && (count != '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 3; i++)
      if (acc[i]) mem[wrPtr + ofs[i]] <= recs[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      ovfSticky <= 1'b0;
    end else begin
      wrPtr     <= wrPtr + PW'(used - count);
      rdPtr     <= rdPtr + PW'(doPop);
      count     <= used - CW'(doPop);
      ovfSticky <= (ovfSticky && !firstDone) || anyDrop;
    end
  end

  assign recValid = (count != '0);
  assign recData  = mem[rdPtr];

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == CW'(DEPTH) && !recPop) |=> (count == CW'(DEPTH)));

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == CW'(DEPTH) && (stb != '0)) |=> ovfSticky);

  // R5
  kind_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (recData[RW-1:RW-2] != 2'd0));
endmodule

// File: rtl/bus_event_logger.sv
module bus_event_logger
  import evlog_pkg::*;
#(
  parameter int MW    = 4,
  parameter int XW    = 4,
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int RW   = 4 + MW + XW + 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enNewReq,
  input  logic          enLastRd,
  input  logic          enLastWr,
  input  logic [4:0]    addrShift,
  input  logic [MW-1:0] nrMasterId,
  input  logic [MW-1:0] nrMasterMask,
  input  logic [AW-1:0] addrLo,
  input  logic [AW-1:0] addrHi,
  input  logic [2:0]    classMask,
  input  logic [1:0]    dirMask,
  input  logic [MW-1:0] lrMasterId,
  input  logic [MW-1:0] lrMasterMask,
  input  logic          trigQualEn,
  input  logic          trigIn,
  input  logic          trigOutEn,
  input  logic          reqValid,
  input  logic [MW-1:0] reqMaster,
  input  logic [XW-1:0] reqXid,
  input  logic          reqWrite,
  input  logic [1:0]    reqClass,
  input  logic [AW-1:0] reqAddr,
  input  logic          rdLastValid,
  input  logic [MW-1:0] rdLastMaster,
  input  logic [XW-1:0] rdLastXid,
  input  logic          wrLastValid,
  input  logic          recPop,
  output logic          recValid,
  output logic [RW-1:0] recData,
  output logic          trigOut
);
  evStrobe_t stb;

  evlog_ctrl #(.MW(MW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .enNewReq(enNewReq), .enLastRd(enLastRd), .enLastWr(enLastWr),
    .nrMasterId(nrMasterId), .nrMasterMask(nrMasterMask),
    .addrLo(addrLo), .addrHi(addrHi), .classMask(classMask), .dirMask(dirMask),
    .lrMasterId(lrMasterId), .lrMasterMask(lrMasterMask),
    .trigQualEn(trigQualEn), .trigIn(trigIn), .trigOutEn(trigOutEn),
    .reqValid(reqValid), .reqMaster(reqMaster), .reqWrite(reqWrite),
    .reqClass(reqClass), .reqAddr(reqAddr),
    .rdLastValid(rdLastValid), .rdLastMaster(rdLastMaster),
    .wrLastValid(wrLastValid), .stb(stb), .trigOut(trigOut)
  );

  evlog_data #(.MW(MW), .XW(XW), .AW(AW), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .addrShift(addrShift),
    .reqMaster(reqMaster), .reqXid(reqXid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .rdLastMaster(rdLastMaster), .rdLastXid(rdLastXid),
    .recPop(recPop), .recValid(recValid), .recData(recData)
  );
endmodule

// File: tb/bus_event_logger_test.sv
`timescale 1ns/1ps
module bus_event_logger_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN;
  logic enNewReq, enLastRd, enLastWr, trigQualEn, trigIn, trigOutEn;
  logic [4:0] addrShift;
  logic [3:0] nrMasterId, nrMasterMask, lrMasterId, lrMasterMask;
  logic [31:0] addrLo, addrHi, reqAddr;
  logic [2:0] classMask;
  logic [1:0] dirMask, reqClass;
  logic reqValid, reqWrite, rdLastValid, wrLastValid, recPop;
  logic [3:0] reqMaster, reqXid, rdLastMaster, rdLastXid;
  logic recValid, trigOut;
  logic [21:0] recData;

  int errors = 0, checks = 0;
  string curReq = "R1";
  logic [21:0] mq[$];
  logic mSticky = 1'b0;
  logic expTrig = 1'b0;

  always #2.5 clk = ~clk;

  bus_event_logger uut (
    .clk(clk), .rstN(rstN), .enNewReq(enNewReq), .enLastRd(enLastRd), .enLastWr(enLastWr),
    .addrShift(addrShift), .nrMasterId(nrMasterId), .nrMasterMask(nrMasterMask),
    .addrLo(addrLo), .addrHi(addrHi), .classMask(classMask), .dirMask(dirMask),
    .lrMasterId(lrMasterId), .lrMasterMask(lrMasterMask), .trigQualEn(trigQualEn),
    .trigIn(trigIn), .trigOutEn(trigOutEn), .reqValid(reqValid), .reqMaster(reqMaster),
    .reqXid(reqXid), .reqWrite(reqWrite), .reqClass(reqClass), .reqAddr(reqAddr),
    .rdLastValid(rdLastValid), .rdLastMaster(rdLastMaster), .rdLastXid(rdLastXid),
    .wrLastValid(wrLastValid), .recPop(recPop), .recValid(recValid), .recData(recData),
    .trigOut(trigOut)
  );

  task automatic check(input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", curReq, act, exp);
    end
  endtask

  // R2 filter model
  function automatic bit nrPass();
    bit cOk;
    cOk = (reqClass == 2'd3) ? 1'b0 : classMask[reqClass];
    return enNewReq && reqValid && (((reqMaster ^ nrMasterId) & nrMasterMask) == 0) &&
           (reqAddr >= addrLo) && (reqAddr <= addrHi) && cOk &&
           (reqWrite ? dirMask[1] : dirMask[0]);
  endfunction

  function automatic logic [9:0] sliceOf(input logic [31:0] a, input logic [4:0] s);
    logic [63:0] w;
    w = {32'b0, a} >> s;
    return w[9:0];
  endfunction

  task automatic step();
    bit qual;
    bit [2:0] ev;
    logic [21:0] r [3];
    logic [21:0] newRecs[$];
    int used;
    bit first, drop;
    qual = !trigQualEn || trigIn;
    ev[0] = qual && nrPass();
    ev[1] = qual && enLastRd && rdLastValid && (((rdLastMaster ^ lrMasterId) & lrMasterMask) == 0);
    ev[2] = qual && enLastWr && wrLastValid;
    r[0] = {2'd1, 1'b0, reqWrite, reqMaster, reqXid, sliceOf(reqAddr, addrShift)};
    r[1] = {2'd2, 2'b0, rdLastMaster, rdLastXid, 10'b0};
    r[2] = {2'd3, 20'b0};
    used = mq.size(); first = 0; drop = 0;
    for (int i = 0; i < 3; i++) begin
      if (ev[i]) begin
        if (used < DEPTH) begin
          r[i][19] = mSticky && !first;
          first = 1; used++;
          newRecs.push_back(r[i]);
        end else drop = 1;
      end
    end
    if (recPop && mq.size() > 0) void'(mq.pop_front());
    foreach (newRecs[k]) mq.push_back(newRecs[k]);
    mSticky = (mSticky && !first) || drop;
    expTrig = trigOutEn && (ev != 0);
    @(posedge clk);
    @(negedge clk);
    check(recValid == (mq.size() > 0), 32'(recValid), 32'(mq.size() > 0));
    if (mq.size() > 0) check(recData == mq[0], 32'(recData), 32'(mq[0]));
    check(trigOut == expTrig, 32'(trigOut), 32'(expTrig));
  endtask

  task automatic idleBus();
    reqValid = 0; rdLastValid = 0; wrLastValid = 0; recPop = 0;
  endtask

  task automatic openCfg();
    enNewReq = 1; enLastRd = 1; enLastWr = 1; addrShift = 0;
    nrMasterId = 0; nrMasterMask = 0; lrMasterId = 0; lrMasterMask = 0;
    addrLo = 0; addrHi = 32'hFFFF_FFFF; classMask = 3'b111; dirMask = 2'b11;
    trigQualEn = 0; trigIn = 0; trigOutEn = 1;
  endtask

  task automatic drain();
    idleBus();
    for (int i = 0; i < 12; i++) begin
      recPop = recValid;
      step();
    end
    recPop = 0;
  endtask

  task automatic setReq(input logic [3:0] m, input logic [3:0] x, input bit w,
                        input logic [1:0] c, input logic [31:0] a);
    reqValid = 1; reqMaster = m; reqXid = x; reqWrite = w; reqClass = c; reqAddr = a;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    openCfg(); idleBus();
    reqMaster = 0; reqXid = 0; reqWrite = 0; reqClass = 0; reqAddr = 0;
    rdLastMaster = 0; rdLastXid = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    curReq = "R1";
    check(recValid == 0, 32'(recValid), 0);
    check(trigOut == 0, 32'(trigOut), 0);

    // R5 R6 record payload and address slice
    curReq = "R5";
    setReq(4'h5, 4'hA, 1, 2'd1, 32'hDEAD_BEEF); step(); idleBus();
    curReq = "R6";
    addrShift = 5'd31; setReq(4'h1, 4'h2, 0, 2'd0, 32'h8000_0000); step(); idleBus();
    addrShift = 5'd12; setReq(4'h3, 4'h4, 1, 2'd2, 32'h1234_5678); step(); idleBus();
    addrShift = 0; drain();

    // R2 filters reject
    curReq = "R2";
    nrMasterId = 4'h3; nrMasterMask = 4'hF;
    setReq(4'h2, 0, 0, 0, 32'h100); step();
    setReq(4'h3, 1, 0, 0, 32'h100); step();
    nrMasterMask = 0; addrLo = 32'h200; addrHi = 32'h2FF;
    setReq(0, 2, 0, 0, 32'h1FF); step();
    setReq(0, 3, 0, 0, 32'h2FF); step();
    addrLo = 0; addrHi = 32'hFFFF_FFFF; classMask = 3'b101;
    setReq(0, 4, 0, 2'd1, 32'h0); step();
    setReq(0, 5, 0, 2'd3, 32'h0); step();
    classMask = 3'b111; dirMask = 2'b10;
    setReq(0, 6, 0, 0, 0); step();
    setReq(0, 7, 1, 0, 0); step();
    dirMask = 2'b11; idleBus(); drain();

    // R3 final-read master filter, final-write unfiltered
    curReq = "R3";
    lrMasterId = 4'h9; lrMasterMask = 4'hC; nrMasterMask = 4'hF; nrMasterId = 4'h0;
    rdLastValid = 1; rdLastMaster = 4'hA; rdLastXid = 4'h7; step();
    rdLastMaster = 4'h4; step();
    rdLastValid = 0; wrLastValid = 1; classMask = 0; dirMask = 0; step();
    openCfg(); idleBus(); drain();

    // R4 enables off
    curReq = "R4";
    enNewReq = 0; enLastRd = 0; enLastWr = 0;
    setReq(1, 1, 0, 0, 0); rdLastValid = 1; wrLastValid = 1; step(); step();
    openCfg(); idleBus(); drain();

    // R7 same-cycle ordering
    curReq = "R7";
    setReq(4'h6, 4'h1, 0, 0, 32'h3FF); rdLastValid = 1; rdLastMaster = 4'h2; rdLastXid = 4'h8;
    wrLastValid = 1; step(); idleBus();
    curReq = "R8"; drain();

    // R9 overflow: fill to 7, triple event leaves two dropped
    curReq = "R9";
    wrLastValid = 1;
    for (int i = 0; i < 7; i++) step();
    setReq(4'hF, 4'hE, 1, 0, 0); rdLastValid = 1; step();
    idleBus(); recPop = 1; step();
    recPop = 0; rdLastValid = 1; rdLastMaster = 4'hB; step();
    rdLastValid = 0; recPop = 1; wrLastValid = 1; step();
    idleBus(); drain();

    // R10 trigger qualification
    curReq = "R10";
    trigQualEn = 1; trigIn = 0; wrLastValid = 1; step(); step();
    trigIn = 1; step(); idleBus(); drain();

    // R11 trigger out gating and dropped events
    curReq = "R11";
    trigOutEn = 0; wrLastValid = 1; step();
    trigOutEn = 1; for (int i = 0; i < 9; i++) step();
    idleBus(); drain();

    // random mix
    curReq = "R8";
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        enNewReq = $urandom_range(0, 7) != 0; enLastRd = $urandom_range(0, 3) != 0;
        enLastWr = $urandom_range(0, 3) != 0; addrShift = 5'($urandom);
        nrMasterId = 4'($urandom); nrMasterMask = 4'($urandom & 32'h3);
        lrMasterId = 4'($urandom); lrMasterMask = 4'($urandom & 32'h1);
        addrLo = $urandom & 32'h3FFF_FFFF; addrHi = addrLo | 32'hC000_0000;
        classMask = 3'($urandom) | 3'b001; dirMask = 2'($urandom) | 2'b01;
        trigQualEn = $urandom_range(0, 1); trigOutEn = $urandom_range(0, 1);
      end
      trigIn = $urandom_range(0, 3) != 0;
      reqValid = $urandom_range(0, 1); reqMaster = 4'($urandom); reqXid = 4'($urandom);
      reqWrite = $urandom_range(0, 1); reqClass = 2'($urandom); reqAddr = $urandom;
      rdLastValid = $urandom_range(0, 1); rdLastMaster = 4'($urandom); rdLastXid = 4'($urandom);
      wrLastValid = $urandom_range(0, 2) == 0;
      recPop = recValid && ($urandom_range(0, 2) == 0);
      step();
    end
    openCfg(); idleBus(); drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule